// File: doc/BRIEF.md
# Double-Buffered Memory-to-Memory DMA Channel

This block is one memory-to-memory DMA channel. It holds two transfer slots, each with a source address, a destination address and a byte count. Software can load the idle slot while the other slot is still moving data. When the running slot finishes, the channel goes straight on to the other slot if that slot is loaded, and otherwise it stops and flags completion. Software uses the next-free-buffer cause to refill a slot and the done cause to learn that the queue has run dry.

The channel has two state machines, and the status register shows both of them. A buffer machine counts the loaded slots. A control machine steps through the memory read and the memory write of each word, and it uses a request/grant memory port to do so. In memcpy mode the channel waits until software arms it with a START bit. Each START covers one run, which ends when the queue empties.

Top module: `m2m_dma_chan`

## Requirements
- R1: After reset every register reads zero. irq and memReq are low.
- R2: The status register is at offset 0x0C. Bits 3:1 hold the control state: 0 idle, 1 stall, 2 memory read, 3 memory write, 4 width-conversion wait. Bits 5:4 hold the buffer state: 0 none, 1 one loaded, 2 two loaded. Bit 6 is DONE. Bit 0 reads zero.
- R3: Writing a nonzero byte count to an unloaded slot loads that slot. Slot 0 count is at 0x10 and slot 1 count is at 0x14. Source addresses are at 0x18 and 0x1C. Destination addresses are at 0x20 and 0x24. While a slot is loaded, writes to its source, destination or count are ignored.
- R4: With the channel enabled (control bit 0), each word is read from the source and then written to the destination. After each write, both addresses advance by the word size and the count drops by the word size, ending at zero.
- R5: In the read and write states, memReq stays high and memAddr and memWe stay stable until memGnt is seen.
- R6: When a slot finishes and the other slot is loaded, the next memory read is issued in the very next cycle. The buffer state goes from 2 to 1, and the next-free-buffer cause (interrupt register bit 2) is set.
- R7: When a slot finishes and no other slot is loaded, the control state becomes stall and the buffer state becomes none. DONE and the done cause (interrupt register bit 1) are set.
- R8: The interrupt register is at offset 0x04. irq is high when the done cause is pending with control bit 2 set, or when the next-free-buffer cause is pending with control bit 21 set. A write to this register clears each cause whose bit is written as 0.
- R9: In memcpy mode (control bit 3), no memory request is made until START (control bit 4, which always reads 0) is written. START is used up when DONE is set, so a newly loaded slot needs another START.
- R10: With control bit 0 clear, the control state returns to idle once any word in flight has been written, and no new read begins.
- R11: The control register is at offset 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 for write, 0 for read |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | DATA_W | Memory write data |
| memGnt | input | 1 | Memory grant; completes the access in the same cycle |
| memRdata | input | DATA_W | Memory read data, valid with memGnt |
| irq | output | 1 | Channel interrupt |

## Verification
The bench targets the hand-over from one slot to the other. A design that leaves an idle cycle there, keeps the buffer state at 2, or raises DONE by mistake is caught by the status snapshot taken in the cycle after the switch. It also writes into a loaded slot while that slot is stalled and reads the slot back. A design that accepts the write would send the copy to the wrong place. Memcpy runs check that START is needed again after DONE; a design that keeps START armed would start copying the new slot by itself. Withholding memGnt checks that the request and the address are held, and a run with the done interrupt masked checks that a pending cause alone does not raise irq.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [2:0] {
    CTL_IDLE    = 3'd0,
    CTL_STALL   = 3'd1,
    CTL_MEMRD   = 3'd2,
    CTL_MEMWR   = 3'd3,
    CTL_BWCWAIT = 3'd4
  } ctlState_t;

  typedef enum logic [1:0] {
    BUF_NONE = 2'd0,
    BUF_ONE  = 2'd1,
    BUF_TWO  = 2'd2
  } bufState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic       advance;
    logic       slot;
    logic [1:0] wrSrc;
    logic [1:0] wrDst;
    logic [1:0] wrCnt;
  } dpStrobe_t;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_INT    = 8'h04;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_CNT    = 8'h10;
  localparam logic [7:0] OFS_SRC    = 8'h18;
  localparam logic [7:0] OFS_DST    = 8'h20;

  localparam int CTRL_EN     = 0;
  localparam int CTRL_DONEIE = 2;
  localparam int CTRL_MEMCPY = 3;
  localparam int CTRL_START  = 4;
  localparam int CTRL_NFBIE  = 21;

  localparam int INT_DONE = 1;
  localparam int INT_NFB  = 2;

endpackage

// File: rtl/dma_chan_datapath.sv
module dma_chan_datapath
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [31:0]                wrData,
  input  logic [DATA_W-1:0]          memRdata,
  output logic [1:0][ADDR_W-1:0]     srcAll,
  output logic [1:0][ADDR_W-1:0]     dstAll,
  output logic [1:0][CNT_W-1:0]      cntAll,
  output logic [ADDR_W-1:0]          curSrc,
  output logic [ADDR_W-1:0]          curDst,
  output logic [DATA_W-1:0]          dataHold,
  output logic                       lastWord
);

  localparam int BYTES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BYTES);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(BYTES);

  logic [31:0] unusedWr;
  assign unusedWr = wrData;

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic hit;
    assign hit = strobe.advance && (strobe.slot == 1'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        srcAll[s] <= '0;
        dstAll[s] <= '0;
        cntAll[s] <= '0;
      end else begin
        if (strobe.wrSrc[s])      srcAll[s] <= wrData[ADDR_W-1:0];
        else if (hit)             srcAll[s] <= srcAll[s] + ADDR_STEP;

        if (strobe.wrDst[s])      dstAll[s] <= wrData[ADDR_W-1:0];
        else if (hit)             dstAll[s] <= dstAll[s] + ADDR_STEP;

        if (strobe.wrCnt[s])      cntAll[s] <= wrData[CNT_W-1:0];
        else if (hit)             cntAll[s] <= (cntAll[s] <= CNT_STEP) ? '0 : cntAll[s] - CNT_STEP;
      end
    end
  end

  assign curSrc   = srcAll[strobe.slot];
  assign curDst   = dstAll[strobe.slot];
  assign lastWord = cntAll[strobe.slot] <= CNT_STEP;

  always_ff @(posedge clk) begin
    if (!rstN)               dataHold <= '0;
    else if (strobe.capture) dataHold <= memRdata;
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  input  logic        memGnt,
  input  logic        lastWord,
  output dpStrobe_t   strobe,
  output logic        memReq,
  output logic        memWe,
  output logic        irq,
  output logic [31:0] ctrlWord,
  output logic [31:0] intWord,
  output logic [31:0] statusWord
);

  ctlState_t ctlQ, ctlD;
  bufState_t bufState;
  logic [1:0] slotValid, validD;
  logic curSlot;
  logic enQ, doneIeQ, memcpyQ, nfbIeQ;
  logic startArmed, donePend, nfbPend;
  logic ctrlWr, intWr;
  logic [1:0] cntWr, srcWr, dstWr, loadHit;
  logic wordDone, slotDone, nextReady, runDone, slotSwap;

  assign ctrlWr = regWrEn && (regAddr == OFS_CTRL);
  assign intWr  = regWrEn && (regAddr == OFS_INT);

  for (genvar s = 0; s < 2; s++) begin : g_dec
    assign cntWr[s]   = regWrEn && (regAddr == OFS_CNT + 8'(4 * s)) && !slotValid[s];
    assign srcWr[s]   = regWrEn && (regAddr == OFS_SRC + 8'(4 * s)) && !slotValid[s];
    assign dstWr[s]   = regWrEn && (regAddr == OFS_DST + 8'(4 * s)) && !slotValid[s];
    assign loadHit[s] = cntWr[s] && (regWrData[CNT_W-1:0] != '0);
  end

  assign wordDone  = (ctlQ == CTL_MEMWR) && memGnt;
  assign slotDone  = wordDone && lastWord;
  assign nextReady = slotValid[~curSlot] || loadHit[~curSlot];
  assign runDone   = slotDone && !nextReady;
  assign slotSwap  = slotDone && nextReady;

  always_comb begin
    ctlD = ctlQ;
    case (ctlQ)
      CTL_IDLE:  if (enQ) ctlD = CTL_STALL;
      CTL_STALL: begin
        if (!enQ) ctlD = CTL_IDLE;
        else if (slotValid[curSlot] && (!memcpyQ || startArmed)) ctlD = CTL_MEMRD;
      end
      CTL_MEMRD: if (memGnt) ctlD = CTL_MEMWR;
      CTL_MEMWR: begin
        if (memGnt) begin
          if (!enQ)         ctlD = CTL_IDLE;
          else if (runDone) ctlD = CTL_STALL;
          else              ctlD = CTL_MEMRD;
        end
      end
      default:   ctlD = CTL_STALL;
    endcase
  end

  always_comb begin
    validD = slotValid;
    if (slotDone) validD[curSlot] = 1'b0;
    validD = validD | loadHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ       <= CTL_IDLE;
      slotValid  <= '0;
      curSlot    <= 1'b0;
      enQ        <= 1'b0;
      doneIeQ    <= 1'b0;
      memcpyQ    <= 1'b0;
      nfbIeQ     <= 1'b0;
      startArmed <= 1'b0;
      donePend   <= 1'b0;
      nfbPend    <= 1'b0;
    end else begin
      ctlQ      <= ctlD;
      slotValid <= validD;
      if (slotSwap)                            curSlot <= ~curSlot;
      else if (slotValid == 2'b00 && |loadHit) curSlot <= loadHit[1];
      if (ctrlWr) begin
        enQ     <= regWrData[CTRL_EN];
        doneIeQ <= regWrData[CTRL_DONEIE];
        memcpyQ <= regWrData[CTRL_MEMCPY];
        nfbIeQ  <= regWrData[CTRL_NFBIE];
      end
      startArmed <= (startArmed && !runDone) || (ctrlWr && regWrData[CTRL_START]);
      donePend   <= (donePend && !(intWr && !regWrData[INT_DONE])) || runDone;
      nfbPend    <= (nfbPend && !(intWr && !regWrData[INT_NFB])) || slotSwap;
    end
  end

  always_comb begin
    case (slotValid)
      2'b00:   bufState = BUF_NONE;
      2'b11:   bufState = BUF_TWO;
      default: bufState = BUF_ONE;
    endcase
  end

  assign memReq = (ctlQ == CTL_MEMRD) || (ctlQ == CTL_MEMWR);
  assign memWe  = (ctlQ == CTL_MEMWR);
  assign irq    = (donePend && doneIeQ) || (nfbPend && nfbIeQ);

  assign strobe.capture = (ctlQ == CTL_MEMRD) && memGnt;
  assign strobe.advance = wordDone;
  assign strobe.slot    = curSlot;
  assign strobe.wrSrc   = srcWr;
  assign strobe.wrDst   = dstWr;
  assign strobe.wrCnt   = cntWr;

  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTRL_EN]     = enQ;
    ctrlWord[CTRL_DONEIE] = doneIeQ;
    ctrlWord[CTRL_MEMCPY] = memcpyQ;
    ctrlWord[CTRL_NFBIE]  = nfbIeQ;
  end

  assign intWord    = {29'd0, nfbPend, donePend, 1'b0};
  assign statusWord = {25'd0, donePend, bufState, ctlQ, 1'b0};

endmodule

// File: rtl/m2m_dma_chan.sv
module m2m_dma_chan
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memGnt,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq
);

  dpStrobe_t strobe;
  logic [1:0][ADDR_W-1:0] srcAll, dstAll;
  logic [1:0][CNT_W-1:0]  cntAll;
  logic [ADDR_W-1:0] curSrc, curDst;
  logic lastWord;
  logic [31:0] ctrlWord, intWord, statusWord;

  dma_chan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .memGnt(memGnt), .lastWord(lastWord),
    .strobe(strobe), .memReq(memReq), .memWe(memWe), .irq(irq),
    .ctrlWord(ctrlWord), .intWord(intWord), .statusWord(statusWord)
  );

  dma_chan_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .memRdata(memRdata), .srcAll(srcAll), .dstAll(dstAll), .cntAll(cntAll),
    .curSrc(curSrc), .curDst(curDst), .dataHold(memWdata), .lastWord(lastWord)
  );

  assign memAddr = memWe ? curDst : curSrc;

  always_comb begin
    case (regAddr)
      OFS_CTRL:      regRdData = ctrlWord;
      OFS_INT:       regRdData = intWord;
      OFS_STATUS:    regRdData = statusWord;
      OFS_CNT:       regRdData = 32'(cntAll[0]);
      OFS_CNT + 8'd4: regRdData = 32'(cntAll[1]);
      OFS_SRC:       regRdData = 32'(srcAll[0]);
      OFS_SRC + 8'd4: regRdData = 32'(srcAll[1]);
      OFS_DST:       regRdData = 32'(dstAll[0]);
      OFS_DST + 8'd4: regRdData = 32'(dstAll[1]);
      default:       regRdData = '0;
    endcase
  end

endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memGnt,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              irq,
  input logic [31:0]       ctrlWord,
  input logic [31:0]       intWord,
  input logic [31:0]       statusWord
);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe));

  assert_status_enc_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[5:4] != 2'd3 && statusWord[3:1] <= 3'd4 && !statusWord[0]);

  assert_swap_gapless_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intWord[2]) && $past(ctrlWord[0]) |-> memReq && !memWe && statusWord[5:4] == 2'd1);

  assert_done_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[6]) && $past(ctrlWord[0]) |->
      statusWord[3:1] == 3'd1 && statusWord[5:4] == 2'd0 && !memReq);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> intWord[1] || intWord[2]);

  assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[0] && !memReq |=> statusWord[3:1] == 3'd0);

endmodule

bind m2m_dma_chan dma_chan_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memGnt(memGnt), .memWe(memWe),
  .memAddr(memAddr), .irq(irq), .ctrlWord(ctrlWord), .intWord(intWord),
  .statusWord(statusWord)
);

// File: tb/test_m2m_dma_chan.sv
`timescale 1ns/1ps
module test_m2m_dma_chan;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe, memGnt, irq;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        gntAllow = 1'b1;

  int checks = 0;
  int fails  = 0;
  int wrCount = 0;
  logic [31:0] mem [0:255];

  always #4 clk = ~clk;

  m2m_dma_chan i_m2m_dma_chan (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memGnt(memGnt), .memRdata(memRdata),
    .irq(irq)
  );

  assign memGnt   = memReq && gntAllow;
  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (memReq && memWe && memGnt) begin
      mem[memAddr[9:2]] <= memWdata;
      wrCount <= wrCount + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitDone();
    logic [31:0] st;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      regRead(8'h0C, st);
      if (st[6]) break;
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(8'h0C, v); check("R1 status", v, 32'h0);
    regRead(8'h04, v); check("R1 int", v, 32'h0);
    regRead(8'h00, v); check("R11 ctrl", v, 32'h0);
    regRead(8'h18, v); check("R1 src0", v, 32'h0);
    check("R1 irq/memReq", {30'd0, irq, memReq}, 32'h0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    int base = wrCount;
    regWrite(8'h18, 32'h000);
    regWrite(8'h20, 32'h200);
    regWrite(8'h10, 32'd16);
    regRead(8'h0C, v); check("R3 one slot loaded", v, 32'h10);
    regWrite(8'h00, 32'h5);
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    regRead(8'h0C, v); check("R7 done status", v, 32'h42);
    for (int i = 0; i < 4; i++) check("R4 copy", mem[8'h80 + i], 32'hA000_0000 + i);
    check("R4 word count", wrCount - base, 32'd4);
    regRead(8'h10, v); check("R4 count zero", v, 32'h0);
    regRead(8'h04, v); check("R8 done cause", v, 32'h2);
    check("R8 irq high", {31'd0, irq}, 32'h1);
    regWrite(8'h04, 32'h0);
    regRead(8'h04, v); check("R8 cleared", v, 32'h0);
    check("R8 irq low", {31'd0, irq}, 32'h0);
    regWrite(8'h00, 32'h0);
    @(negedge clk);
    regRead(8'h0C, v); check("R10 idle", v, 32'h0);
  endtask

  task automatic testDouble();
    logic [31:0] v;
    int base = wrCount;
    regWrite(8'h18, 32'h010); regWrite(8'h20, 32'h240); regWrite(8'h10, 32'd8);
    regWrite(8'h1C, 32'h020); regWrite(8'h24, 32'h280); regWrite(8'h14, 32'd12);
    regRead(8'h0C, v); check("R3 two slots", v, 32'h20);
    regWrite(8'h1C, 32'h3FC);
    regRead(8'h1C, v); check("R3 loaded slot write ignored", v, 32'h020);
    regWrite(8'h00, 32'h0020_0001);
    for (int i = 0; i < 200 && !irq; i++) @(negedge clk);
    regRead(8'h0C, v); check("R6 gapless switch status", v, 32'h14);
    regRead(8'h04, v); check("R6 nfb cause", v, 32'h4);
    regWrite(8'h04, 32'h0);
    waitDone();
    regRead(8'h04, v); check("R8 done pending masked", v, 32'h2);
    check("R8 irq masked", {31'd0, irq}, 32'h0);
    for (int i = 0; i < 2; i++) check("R6 copy slot0", mem[8'h90 + i], 32'hA000_0004 + i);
    for (int i = 0; i < 3; i++) check("R6 copy slot1", mem[8'hA0 + i], 32'hA000_0008 + i);
    check("R6 word count", wrCount - base, 32'd5);
    regWrite(8'h00, 32'h0);
    regWrite(8'h04, 32'h0);
  endtask

  task automatic testMemcpy();
    logic [31:0] v;
    int base = wrCount;
    regWrite(8'h18, 32'h040); regWrite(8'h20, 32'h300); regWrite(8'h10, 32'd8);
    regWrite(8'h00, 32'h9);
    repeat (20) @(negedge clk);
    check("R9 no start no traffic", wrCount - base, 32'd0);
    regRead(8'h0C, v); check("R9 stalled", v, 32'h12);
    regWrite(8'h18, 32'h3F0);
    regRead(8'h18, v); check("R3 stalled slot write ignored", v, 32'h040);
    gntAllow = 1'b0;
    regWrite(8'h00, 32'h19);
    repeat (10) @(negedge clk);
    regRead(8'h0C, v); check("R5 held in read", v, 32'h14);
    check("R5 request and address held", {memReq, memAddr[30:0]}, 32'h8000_0040);
    regRead(8'h00, v); check("R9 start reads zero", v, 32'h9);
    gntAllow = 1'b1;
    waitDone();
    regRead(8'h0C, v); check("R7 memcpy done", v, 32'h42);
    for (int i = 0; i < 2; i++) check("R9 copy", mem[8'hC0 + i], 32'hA000_0010 + i);
    regWrite(8'h04, 32'h0);
    base = wrCount;
    regWrite(8'h1C, 32'h050); regWrite(8'h24, 32'h340); regWrite(8'h14, 32'd4);
    repeat (20) @(negedge clk);
    check("R9 start consumed", wrCount - base, 32'd0);
    regWrite(8'h00, 32'h19);
    waitDone();
    check("R9 restart copy", mem[8'hD0], 32'hA000_0014);
    regWrite(8'h00, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testDouble();
    testMemcpy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule